// File: doc/BRIEF.md
# Four-Bit I2C Port Expander

This block is an I2C target that gives a host controller a four-bit general-purpose I/O port. The bus pins are sampled in the system clock domain. SDA is driven open-drain style: `sda_oe` high pulls the line low. The block detects START and STOP conditions. It acknowledges its own fixed seven-bit address and shifts bytes in or out.

Inside are a two-bit pointer and four byte-wide registers:
- the pin-level view, which is read-only;
- the drive values;
- a per-pin read inversion mask;
- a per-pin direction mask.

In a write transfer, the first byte after the address is a command byte that loads the pointer. Any further bytes in the same transfer go to the register the pointer selects. A read transfer returns the selected register. It can follow a repeated START, or come as a fresh transfer.

Each pad has a drive value output and an output-enable output, plus a pad level input. Each pad level input passes through a synchronizer before it is read.

Top module: `gpx4_port_expander`

## Requirements
- R1: After reset the direction mask is all ones, so `pad_oe` is 0000. The drive register is all ones, so `pad_o` is 1111. The inversion mask is 0 and `sda_oe` is low.
- R2: The block acknowledges an address byte only when its upper seven bits equal the parameter `DEV_ADDR`. With any other address, SDA stays released until the next START. No register changes in that transfer.
- R3: In a write transfer, bits [1:0] of the first byte after the address load the pointer, and bits [7:2] are ignored. Every written byte is acknowledged. The pointer changes only on that first byte. Later bytes all go to the selected register, and the last one wins.
- R4: Pointer value 1 selects the drive register. Its low four bits appear on `pad_o`.
- R5: Pointer value 3 selects the direction mask. Mask bit 1 makes a pin an input (`pad_oe` bit 0). Mask bit 0 drives the pin (`pad_oe` bit 1).
- R6: Pointer value 0 selects the pin-level view. Its low nibble is the synchronized `pad_i` level, read whatever the direction mask holds. Its high nibble reads 1111.
- R7: Pointer value 2 selects the inversion mask. A mask bit of 1 inverts the matching pin bit in the pin-level view.
- R8: A data byte written while the pointer is 0 is acknowledged but changes no register.
- R9: A read transfer, whether after a repeated START or a new START, returns the register the pointer last selected and leaves the pointer unchanged. When the controller acknowledges a read byte, the next byte is the same register again.
- R10: The block changes `sda_oe` only while SCL is low. It releases SDA for the controller's acknowledge slot. After a NACK it keeps SDA released.
- R11: Bits [7:4] of the drive, inversion and direction registers always read back as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High pulls SDA low |
| pad_i | input | 4 | Pad levels |
| pad_o | output | 4 | Pad drive values |
| pad_oe | output | 4 | Pad output enables, 1 = drive |

## Verification
The bench builds the block with its defaults:
- `DEV_ADDR` is 7'h41.
- There are four port bits.
- Both pads and bus pins use two-stage synchronizers.

Each SCL quarter period is eight clocks. That margin covers the three-clock path from a line edge to an `sda_oe` change, so acknowledge and data bits settle well before the controller samples them. It also lets the bench reach:
- pointer changes through repeated START;
- multi-byte reads that repeat one register;
- a stray address in the middle of the run.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    typedef logic [7:0] byte_t;

    // Register selected by the pointer; the encoding is decoded by the register bank.
    typedef enum logic [1:0] {
        SEL_PINS  = 2'd0,
        SEL_DRIVE = 2'd1,
        SEL_INV   = 2'd2,
        SEL_DIR   = 2'd3
    } sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_A,
        ST_WRITE,
        ST_ACK_W,
        ST_READ,
        ST_ACK_R
    } bus_st_e;

    // One received data byte handed from the bus engine to the register bank.
    typedef struct packed {
        logic  valid;
        logic  first;
        byte_t data;
    } wr_evt_t;

    function automatic logic addr_hit(input byte_t b, input logic [6:0] a);
        return b[7:1] == a;
    endfunction

    // Unused upper bits of a register read back as ones.
    function automatic byte_t fill_ones(input byte_t v, input int unsigned w);
        byte_t r;
        for (int i = 0; i < 8; i++) begin
            r[i] = (i < w) ? v[i] : 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= d;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpx_bus.sv
module gpx_bus
    import gpx_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h41
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    input  byte_t   rd_byte,
    output logic    sda_oe,
    output wr_evt_t wr
);
    logic    scl_q, sda_q;
    bus_st_e st;
    byte_t   sh;
    logic [3:0] cnt;
    logic    rnw, nack, first;
    logic    scl_rise, scl_fall, start_c, stop_c;

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            st     <= ST_IDLE;
            sh     <= '0;
            cnt    <= '0;
            rnw    <= 1'b0;
            nack   <= 1'b0;
            first  <= 1'b0;
            sda_oe <= 1'b0;
            wr     <= '0;
        end else begin
            scl_q    <= scl_s;
            sda_q    <= sda_s;
            wr.valid <= 1'b0;
            if (start_c) begin
                st     <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_c) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (st)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            sh  <= {sh[6:0], sda_s};
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            if (addr_hit(sh, DEV_ADDR)) begin
                                st     <= ST_ACK_A;
                                sda_oe <= 1'b1;
                                rnw    <= sh[0];
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK_A: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rnw) begin
                                st     <= ST_READ;
                                sh     <= rd_byte;
                                sda_oe <= ~rd_byte[7];
                            end else begin
                                st     <= ST_WRITE;
                                sda_oe <= 1'b0;
                                first  <= 1'b1;
                            end
                        end
                    end
                    ST_WRITE: begin
                        if (scl_rise) begin
                            sh  <= {sh[6:0], sda_s};
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            st       <= ST_ACK_W;
                            sda_oe   <= 1'b1;
                            wr.valid <= 1'b1;
                            wr.first <= first;
                            wr.data  <= sh;
                            first    <= 1'b0;
                        end
                    end
                    ST_ACK_W: begin
                        if (scl_fall) begin
                            st     <= ST_WRITE;
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                        end
                    end
                    ST_READ: begin
                        if (scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (cnt == 4'd8) begin
                                st     <= ST_ACK_R;
                                sda_oe <= 1'b0;
                            end else begin
                                sh     <= {sh[6:0], 1'b0};
                                sda_oe <= ~sh[6];
                            end
                        end
                    end
                    ST_ACK_R: begin
                        if (scl_rise) begin
                            nack <= sda_s;
                        end else if (scl_fall) begin
                            if (nack) begin
                                st <= ST_IDLE;
                            end else begin
                                st     <= ST_READ;
                                cnt    <= '0;
                                sh     <= rd_byte;
                                sda_oe <= ~rd_byte[7];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10: SDA drive never moves while SCL stays high outside START/STOP.
    p_sda_steady_r10: assert property (@(posedge clk) disable iff (rst)
        (scl_s && scl_q && !start_c && !stop_c) |=> $stable(sda_oe));

    // R2: an idle engine never holds SDA low.
    p_idle_release_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe);

    // R9: read phases never hand a write to the register bank.
    p_no_write_in_read_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_READ || st == ST_ACK_R) |-> !wr.valid);
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
    import gpx_pkg::*;
#(
    parameter int PORT_W = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_evt_t           wr,
    input  logic [PORT_W-1:0] pad_i,
    output byte_t             rd_byte,
    output logic [PORT_W-1:0] pad_o,
    output logic [PORT_W-1:0] pad_oe
);
    sel_e              ptr_q;
    logic [PORT_W-1:0] drv_q, inv_q, dir_q, pad_s;

    gpx_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_pad_sync (
        .clk(clk), .rst(rst), .d(pad_i), .q(pad_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= SEL_PINS;
            drv_q <= '1;
            inv_q <= '0;
            dir_q <= '1;
        end else if (wr.valid) begin
            if (wr.first) begin
                ptr_q <= sel_e'(wr.data[1:0]);
            end else begin
                unique case (ptr_q)
                    SEL_DRIVE: drv_q <= wr.data[PORT_W-1:0];
                    SEL_INV:   inv_q <= wr.data[PORT_W-1:0];
                    SEL_DIR:   dir_q <= wr.data[PORT_W-1:0];
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (ptr_q)
            SEL_PINS:  rd_byte = fill_ones(byte_t'(pad_s ^ inv_q), PORT_W);
            SEL_DRIVE: rd_byte = fill_ones(byte_t'(drv_q), PORT_W);
            SEL_INV:   rd_byte = fill_ones(byte_t'(inv_q), PORT_W);
            default:   rd_byte = fill_ones(byte_t'(dir_q), PORT_W);
        endcase
    end

    assign pad_o  = drv_q;
    assign pad_oe = ~dir_q;

    // R8: data aimed at the pin-level view leaves every writable register alone.
    p_pins_ro_r8: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && !wr.first && ptr_q == SEL_PINS)
            |=> ($stable(drv_q) && $stable(inv_q) && $stable(dir_q)));

    // R3: only the command byte may move the pointer.
    p_ptr_only_first_r3: assert property (@(posedge clk) disable iff (rst)
        !(wr.valid && wr.first) |=> $stable(ptr_q));
endmodule

// File: rtl/gpx4_port_expander.sv
module gpx4_port_expander
    import gpx_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h41,
    parameter int PORT_W = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [PORT_W-1:0] pad_i,
    output logic [PORT_W-1:0] pad_o,
    output logic [PORT_W-1:0] pad_oe
);
    logic [1:0] bus_s;
    byte_t      rd_byte;
    wr_evt_t    wr;

    gpx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_bus_sync (
        .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(bus_s)
    );

    gpx_bus #(.DEV_ADDR(DEV_ADDR)) u_bus (
        .clk(clk), .rst(rst), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
        .rd_byte(rd_byte), .sda_oe(sda_oe), .wr(wr)
    );

    gpx_regs #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_regs (
        .clk(clk), .rst(rst), .wr(wr), .pad_i(pad_i),
        .rd_byte(rd_byte), .pad_o(pad_o), .pad_oe(pad_oe)
    );

    // R1: leaving reset, every pin is an input.
    p_reset_inputs_r1: assert property (@(posedge clk)
        $fell(rst) |-> (pad_oe == '0));
endmodule

// File: tb/tb_gpx4_port_expander.sv
module tb_gpx4_port_expander;
    localparam int CLK_P = 10;
    localparam int Q = 8;
    localparam logic [6:0] DEV = 7'h41;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [3:0] pad_i = 4'b0000;
    logic [3:0] pad_o, pad_oe;

    int checks = 0;
    int errors = 0;
    logic [3:0] m_drv = 4'hF, m_inv = 4'h0, m_dir = 4'hF;

    always #(CLK_P/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    gpx4_port_expander dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic qw();
        #(Q*CLK_P);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
    endtask

    task automatic send(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
        end
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
        ack = ~sda_line;
        qw(); scl_m = 1'b0; qw();
    endtask

    task automatic recv(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            scl_m = 1'b1; qw(); b[i] = sda_line; qw(); scl_m = 1'b0; qw(); qw();
        end
        sda_m = ~give_ack; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
        sda_m = 1'b1;
    endtask

    task automatic wr_reg(input string tag, input logic [7:0] cmd, input logic [7:0] data);
        logic a;
        i2c_start();
        send({DEV, 1'b0}, a); chk({tag, " addr ack"}, {7'b0, a}, 8'h01);
        send(cmd, a);         chk({tag, " cmd ack"},  {7'b0, a}, 8'h01);
        send(data, a);        chk({tag, " data ack"}, {7'b0, a}, 8'h01);
        i2c_stop();
    endtask

    task automatic rd_reg(input logic [7:0] cmd, output logic [7:0] b);
        logic a;
        i2c_start();
        send({DEV, 1'b0}, a);
        send(cmd, a);
        i2c_start();
        send({DEV, 1'b1}, a);
        recv(1'b0, b);
        i2c_stop();
    endtask

    task automatic t_reset();
        logic [7:0] b;
        chk("R1 pad_oe", {4'h0, pad_oe}, 8'h00);
        chk("R1 pad_o", {4'h0, pad_o}, 8'h0F);
        chk("R1 sda_oe", {7'b0, sda_oe}, 8'h00);
        rd_reg(8'h03, b); chk("R11 dir readback after reset", b, 8'hFF);
        rd_reg(8'h02, b); chk("R11 inv readback after reset", b, 8'hF0);
    endtask

    task automatic t_drive_dir();
        logic [7:0] b;
        wr_reg("R4", 8'h01, 8'hA5); m_drv = 4'h5;
        chk("R4 pad_o", {4'h0, pad_o}, {4'h0, m_drv});
        rd_reg(8'h01, b); chk("R11 drive readback", b, {4'hF, m_drv});
        wr_reg("R5", 8'h03, 8'h03); m_dir = 4'h3;
        chk("R5 pad_oe", {4'h0, pad_oe}, {4'h0, ~m_dir});
    endtask

    task automatic t_pins();
        logic [7:0] b;
        pad_i = 4'b1010;
        rd_reg(8'h00, b); chk("R6 pins with mixed directions", b, {4'hF, pad_i ^ m_inv});
        pad_i = 4'b0110;
        rd_reg(8'h00, b); chk("R6 pins second pattern", b, {4'hF, pad_i ^ m_inv});
    endtask

    task automatic t_inv();
        logic [7:0] b;
        wr_reg("R7", 8'h02, 8'h09); m_inv = 4'h9;
        rd_reg(8'h00, b); chk("R7 inverted pins", b, {4'hF, pad_i ^ m_inv});
        rd_reg(8'h02, b); chk("R7 inv readback", b, {4'hF, m_inv});
    endtask

    task automatic t_ro();
        logic [7:0] b;
        wr_reg("R8", 8'h00, 8'h00);
        chk("R8 pad_o unchanged", {4'h0, pad_o}, {4'h0, m_drv});
        chk("R8 pad_oe unchanged", {4'h0, pad_oe}, {4'h0, ~m_dir});
        rd_reg(8'h02, b); chk("R8 inv unchanged", b, {4'hF, m_inv});
    endtask

    task automatic t_cmd_multi();
        logic a;
        i2c_start();
        send({DEV, 1'b0}, a);
        send(8'hFD, a); chk("R3 cmd upper bits ignored ack", {7'b0, a}, 8'h01);
        send(8'h03, a); chk("R3 second data ack", {7'b0, a}, 8'h01);
        send(8'h0C, a); chk("R3 third data ack", {7'b0, a}, 8'h01);
        i2c_stop();
        m_drv = 4'hC;
        chk("R3 last byte wins on pad_o", {4'h0, pad_o}, {4'h0, m_drv});
    endtask

    task automatic t_repeat_read();
        logic a;
        logic [7:0] b;
        i2c_start();
        send({DEV, 1'b0}, a);
        send(8'h01, a);
        i2c_start();
        send({DEV, 1'b1}, a); chk("R9 read addr ack", {7'b0, a}, 8'h01);
        recv(1'b1, b); chk("R9 first byte", b, {4'hF, m_drv});
        recv(1'b1, b); chk("R9 repeated byte", b, {4'hF, m_drv});
        recv(1'b0, b); chk("R9 last byte", b, {4'hF, m_drv});
        i2c_stop();
        chk("R10 SDA released after NACK", {7'b0, sda_oe}, 8'h00);
        i2c_start();
        send({DEV, 1'b1}, a);
        recv(1'b0, b); chk("R9 fresh read keeps pointer", b, {4'hF, m_drv});
        i2c_stop();
    endtask

    task automatic t_stray_addr();
        logic a;
        logic [7:0] b;
        i2c_start();
        send({DEV ^ 7'h01, 1'b0}, a); chk("R2 foreign address not acked", {7'b0, a}, 8'h00);
        send(8'h01, a); chk("R2 foreign byte not acked", {7'b0, a}, 8'h00);
        send(8'h00, a);
        i2c_stop();
        chk("R2 pad_o untouched", {4'h0, pad_o}, {4'h0, m_drv});
        i2c_start();
        send({DEV, 1'b1}, a); chk("R2 own address acked", {7'b0, a}, 8'h01);
        recv(1'b0, b); chk("R2 pointer untouched", b, {4'hF, m_drv});
        i2c_stop();
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_drive_dir();
        t_pins();
        t_inv();
        t_ro();
        t_cmd_multi();
        t_repeat_read();
        t_stray_addr();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule